// File: doc/BRIEF.md
# UART Receive Error Status and Character Buffer

This block sits behind a UART's bit-level receiver. The receiver delivers one strobe per event: a character with its data, a detected break, a framing error or a parity error. The block stores the characters in a small FIFO. It records each kind of error in a sticky flag. It raises one interrupt line for the flags that software has chosen to enable.

Software talks to the block over a small register bus with three word addresses:
- Address 0 is the status word. Reading it returns the four flags. Writing ones to it clears the matching flags.
- Address 1 is the control word, which holds the four interrupt enables.
- Address 2 is the data port. Reading it pops one character from the FIFO.

A read returns its value one clock after the read strobe. The value then holds until the next read.

When a character arrives while the FIFO is full, the block drops that character and sets the overrun flag. The characters already buffered stay in place and in order.

Top module: `uart_rx_err_status`

## Requirements
- R1: After reset every flag is 0, the control word reads 0, `irq` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: Reading address 0 returns break at bit 15, framing error at bit 14, parity error at bit 13 and overrun at bit 12. Bits 11 to 0 read as 0.
- R3: A flag that is set stays set through later events of any kind until software clears it.
- R4: Writing address 0 clears each flag whose bit in the written word is 1. Flags whose bit is 0 keep their value.
- R5: If `rx_valid` is high on a clock edge while `fifo_full` is high, the overrun flag (bit 12) is set and that character is not stored.
- R6: The FIFO holds 8 characters. `fifo_full` goes to 1 once 8 characters are stored. Characters read back in arrival order, and an overrun leaves the stored characters unchanged.
- R7: The control word has enables at bits 15 to 12, in the same order as the status flags, and reads back as written with bits 11 to 0 zero. `irq` is registered: it equals the OR of (flag AND enable) taken from the values present one clock earlier.
- R8: When an error strobe and a write-1 clear of the same bit arrive on the same edge, the flag ends up set.
- R9: The break, framing and parity strobes set their flags whatever the FIFO state. A character that arrives with a framing or parity error is still stored if there is room.
- R10: A read of address 2 pops one character, which appears on `reg_rdata[7:0]` with the upper bits 0 one clock later. A read of address 2 while the FIFO is empty returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Break detected strobe |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_parity_err | input | 1 | Parity error strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 control, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid one clock after `reg_rd` |
| fifo_full | output | 1 | FIFO holds 8 characters |
| fifo_empty | output | 1 | FIFO holds no characters |
| irq | output | 1 | Level interrupt for enabled, set flags |

## Verification
The assertions assume the following about the inputs:
- Receiver strobes are single-cycle pulses.
- A register read and a register write never fall in the same cycle.
- Only addresses 0 to 2 are used.

The stimulus respects all three. It changes inputs only on the falling edge, and it raises `reg_rd` and `reg_wr` in separate cycles. The one deliberate overlap is a clear that meets an error strobe on the same edge, which exists to exercise R8.

// File: rtl/uart_rx_err_pkg.sv
package uart_rx_err_pkg;
  localparam int NFLAG = 4;

  // index into the flag vector; vector [3:0] maps onto status bits [15:12]
  localparam int FLG_OVR = 0;
  localparam int FLG_PAR = 1;
  localparam int FLG_FRM = 2;
  localparam int FLG_BRK = 3;

  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count_q, count_d;
  logic             do_push, do_pop;

  assign do_push = wr_en && !full;
  assign do_pop  = rd_en && !empty;
  assign count_d = count_q + CW'(do_push) - CW'(do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      full    <= 1'b0;
      empty   <= 1'b1;
      rd_data <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (rd_en)   rd_data <= empty ? '0 : mem[rd_ptr];
      count_q <= count_d;
      full    <= (count_d == CW'(DEPTH));
      empty   <= (count_d == '0);
    end
  end

  // R5
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    full && !rd_en |=> full);

  // R6
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_mask,
  input  logic [NF-1:0] enable,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] clr_eff, flags_d;

  assign clr_eff = clr_wr ? clr_mask : '0;
  // set is OR-ed after the clear so a same-cycle event survives
  assign flags_d = (flags & ~clr_eff) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |(flags & enable);
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      flags[i] && !(clr_wr && clr_mask[i]) |=> flags[i]);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
  end

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|flags));
endmodule

// File: rtl/uart_rx_err_status.sv
module uart_rx_err_status #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int REG_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_break,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              irq
);
  import uart_rx_err_pkg::*;

  localparam int STAT_LSB = REG_W - NFLAG;

  reg_addr_e          addr;
  logic [NFLAG-1:0]   ctrl_en_q, flags, set_vec, wmask;
  logic [DATA_W-1:0]  fifo_dout;
  logic               fifo_wr, fifo_rd, clr_wr;
  logic               rsel_data_q;
  logic [REG_W-1:0]   capt_q;
  logic               unused_wdata_low;

  assign addr             = reg_addr_e'(reg_addr);
  assign wmask            = reg_wdata[REG_W-1 -: NFLAG];
  assign unused_wdata_low = ^reg_wdata[STAT_LSB-1:0];
  assign clr_wr           = reg_wr && (addr == ADDR_STAT);
  assign fifo_wr          = rx_valid && !fifo_full;
  assign fifo_rd          = reg_rd && (addr == ADDR_DATA);

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_BRK] = rx_break;
    set_vec[FLG_FRM] = rx_frame_err;
    set_vec[FLG_PAR] = rx_parity_err;
    set_vec[FLG_OVR] = rx_valid && fifo_full;
  end

  rx_char_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fifo_wr),
    .wr_data (rx_data),
    .rd_en   (fifo_rd),
    .rd_data (fifo_dout),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  rx_err_flags #(.NF(NFLAG)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set      (set_vec),
    .clr_wr   (clr_wr),
    .clr_mask (wmask),
    .enable   (ctrl_en_q),
    .flags    (flags),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q   <= '0;
      rsel_data_q <= 1'b0;
      capt_q      <= '0;
    end else begin
      if (reg_wr && addr == ADDR_CTRL) ctrl_en_q <= wmask;
      if (reg_rd) begin
        rsel_data_q <= (addr == ADDR_DATA);
        case (addr)
          ADDR_STAT: capt_q <= {flags, {STAT_LSB{1'b0}}};
          ADDR_CTRL: capt_q <= {ctrl_en_q, {STAT_LSB{1'b0}}};
          default:   capt_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rsel_data_q ? {{(REG_W-DATA_W){1'b0}}, fifo_dout} : capt_q;

  // R5
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && fifo_full |=> flags[FLG_OVR]);

  // R6
  full_stays_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && fifo_full && !fifo_rd |=> fifo_full);
endmodule

// File: tb/test_uart_rx_err_status.sv
module test_uart_rx_err_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_break = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic [7:0]  rx_data = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        fifo_full, fifo_empty, irq;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_err_status i_uart_rx_err_status (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rx_event(logic v, logic [7:0] d, logic b, logic fe, logic pe);
    rx_valid = v; rx_data = d; rx_break = b; rx_frame_err = fe; rx_parity_err = pe;
    @(negedge clk);
    rx_valid = 0; rx_break = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(2'd0, v); chk("R1 status", v, 16'h0000);
    reg_read(2'd1, v); chk("R1 control", v, 16'h0000);
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 empty", 16'(fifo_empty), 16'h1);
    chk("R1 full", 16'(fifo_full), 16'h0);
  endtask

  task automatic t_flag_bits();
    logic [15:0] v;
    rx_event(0, 8'h00, 1, 0, 0);
    reg_read(2'd0, v); chk("R2 break bit15", v, 16'h8000);
    chk("R9 break with empty fifo", 16'(fifo_empty), 16'h1);
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, v); chk("R4 write 0 keeps", v, 16'h8000);
    reg_write(2'd0, 16'h8000);
    reg_read(2'd0, v); chk("R4 write 1 clears", v, 16'h0000);
    rx_event(1, 8'h41, 0, 1, 0);
    reg_read(2'd0, v); chk("R2 frame bit14", v, 16'h4000);
    rx_event(1, 8'h42, 0, 0, 1);
    reg_read(2'd0, v); chk("R2 parity bit13", v, 16'h6000);
    rx_event(1, 8'h43, 0, 0, 0);
    rx_event(0, 8'h00, 1, 0, 0);
    reg_read(2'd0, v); chk("R3 sticky after more events", v, 16'he000);
    reg_write(2'd0, 16'h4000);
    reg_read(2'd0, v); chk("R4 partial clear", v, 16'ha000);
    reg_read(2'd2, v); chk("R9 framed char stored", v, 16'h0041);
    reg_read(2'd2, v); chk("R9 parity char stored", v, 16'h0042);
    reg_read(2'd2, v); chk("R10 clean char", v, 16'h0043);
    reg_write(2'd0, 16'hf000);
    reg_read(2'd0, v); chk("R4 clear all", v, 16'h0000);
  endtask

  task automatic t_fill_overrun();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      chk("R6 not full early", 16'(fifo_full), 16'h0);
      rx_event(1, 8'h10 + 8'(i), 0, 0, 0);
    end
    chk("R6 full at 8", 16'(fifo_full), 16'h1);
    reg_read(2'd0, v); chk("R5 no overrun yet", v, 16'h0000);
    rx_event(1, 8'hee, 0, 1, 0);
    reg_read(2'd0, v); chk("R5 overrun and R9 frame while full", v, 16'h5000);
    chk("R5 still full", 16'(fifo_full), 16'h1);
    for (int i = 0; i < 8; i++) begin
      reg_read(2'd2, v); chk("R6 order kept", v, 16'h0010 + 16'(i));
    end
    chk("R6 empty after drain", 16'(fifo_empty), 16'h1);
    reg_read(2'd2, v); chk("R10 empty read zero", v, 16'h0000);
    rx_event(1, 8'h77, 0, 0, 0);
    reg_read(2'd2, v); chk("R10 empty read popped nothing", v, 16'h0077);
    reg_write(2'd0, 16'hf000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    reg_write(2'd1, 16'h1fff);
    reg_read(2'd1, v); chk("R7 control readback", v, 16'h1000);
    rx_event(0, 8'h00, 1, 0, 0);
    @(negedge clk);
    chk("R7 disabled flag no irq", 16'(irq), 16'h0);
    reg_write(2'd1, 16'h8000);
    chk("R7 irq not before register stage", 16'(irq), 16'h0);
    @(negedge clk);
    chk("R7 irq on enabled flag", 16'(irq), 16'h1);
    reg_write(2'd0, 16'h8000);
    @(negedge clk);
    chk("R7 irq drops after clear", 16'(irq), 16'h0);
    reg_write(2'd1, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    rx_event(0, 8'h00, 0, 0, 1);
    rx_parity_err = 1;
    reg_write(2'd0, 16'h2000);
    rx_parity_err = 0;
    reg_read(2'd0, v); chk("R8 set wins over clear", v, 16'h2000);
    reg_write(2'd0, 16'h2000);
    reg_read(2'd0, v); chk("R8 later clear works", v, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_flag_bits();
    t_fill_overrun();
    t_irq();
    t_set_wins();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule